// File: doc/BRIEF.md
# Dual-Select Static RAM Model

This block is a synthesizable model of a small static memory holding 256 words of 4 bits. Data enters and leaves on two separate 4-bit buses. The device is enabled by a pair of chip selects of opposite polarity. A mute input can silence the output at any time, and a single direction input picks between reading and writing. The three-state driver of a real part is represented by a drive-enable flag. While that flag is low, the data output is held at zero. A wrapper at the pad level can turn the pair into a true tri-state bus.

A write is captured on the rising clock edge of any cycle in which the device is selected and the direction input asks for a write. The read path is combinational from the array. During a write, the output follows the incoming data unless the mute input is high, so the part can share a common data bus with its writer. While the device is deselected it drives nothing, and its direction and mute inputs have no effect on the stored words.

Top module: `dsel_sram`

## Requirements
- R1: The device counts as selected only when `sel_n` is 0 and `sel` is 1. In all other cases `dout_en` is 0.
- R2: When selected with `mute` = 0 and `rd_wr` = 1 (read), `dout_en` is 1 and `dout` equals the word currently stored at `addr`.
- R3: When selected with `rd_wr` = 0 (write), the word at `addr` takes the value of `din` at the rising clock edge, and a later read of that address returns it.
- R4: When selected with `rd_wr` = 0 and `mute` = 0, `dout_en` is 1 and `dout` equals `din` in the same cycle.
- R5: With `mute` = 1, `dout_en` is 0 whatever the selects and `rd_wr` are. A write requested in that cycle is still stored.
- R6: When deselected, `dout_en` is 0, and no word changes, whatever `rd_wr`, `mute`, `addr` and `din` do and for however many cycles the deselect lasts.
- R7: Whenever `dout_en` is 0, `dout` is all zeros.
- R8: After `rst_n` is low, every word reads back as zero (default `CLEAR_ON_RESET` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array when enabled |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| mute | input | 1 | Output disable, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| dout | output | 4 | Read data or write echo; zero when not driving |
| dout_en | output | 1 | Drive enable standing for the three-state driver |

## Verification
The hardest situation to reach is stored data surviving a long deselect while the other inputs keep asking for writes. Random control inputs rarely hold the selects off for many cycles in a row and then read back the very words written earlier. The bench therefore fills a set of addresses in a directed phase. It then runs dozens of deselected cycles with `rd_wr` low, random `din` and addresses aimed at those words, and reads each word back against a shadow array. Random traffic is concentrated on sixteen addresses, so that writes, muted writes and reads of the same word follow each other closely.

// File: rtl/dsel_sram_pkg.sv
`timescale 1ns/1ps
package dsel_sram_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_READ  = 2'd1,
      MODE_WRITE = 2'd2
   } dsel_mode_t;
endpackage

// File: rtl/dsel_mode_decode.sv
`timescale 1ns/1ps
module dsel_mode_decode
   import dsel_sram_pkg::*;
(
   input  logic       sel_n,
   input  logic       sel,
   input  logic       mute,
   input  logic       rd_wr,
   output dsel_mode_t mode,
   output logic       wr_go,
   output logic       drive_on,
   output logic       echo_din
);
   logic chosen;

   always_comb begin
      chosen = ~sel_n & sel;
      if (!chosen)
         mode = MODE_IDLE;
      else if (rd_wr)
         mode = MODE_READ;
      else
         mode = MODE_WRITE;
   end

   always_comb begin
      wr_go    = (mode == MODE_WRITE);
      drive_on = (mode != MODE_IDLE) && !mute;
      echo_din = (mode == MODE_WRITE);
   end
endmodule

// File: rtl/dsel_store.sv
`timescale 1ns/1ps
module dsel_store #(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (wr_go) begin
               cells[addr] <= din;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (wr_go) cells[addr] <= din;
         end
      end
   endgenerate

   assign rd_data = cells[addr];
endmodule

// File: rtl/dsel_out_stage.sv
`timescale 1ns/1ps
module dsel_out_stage #(
   parameter int DATA_W = 4
) (
   input  logic              drive_on,
   input  logic              echo_din,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   always_comb begin
      dout_en = drive_on;
      if (!drive_on)
         dout = '0;
      else if (echo_din)
         dout = din;
      else
         dout = rd_data;
   end
endmodule

// File: rtl/dsel_sram.sv
`timescale 1ns/1ps
module dsel_sram
   import dsel_sram_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              sel_n,
   input  logic              sel,
   input  logic              mute,
   input  logic              rd_wr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("dsel_sram: ADDR_W must lie in 1..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dsel_sram: DATA_W must be at least 1");
      end
   endgenerate

   dsel_mode_t        mode;
   logic              wr_go;
   logic              drive_on;
   logic              echo_din;
   logic [DATA_W-1:0] rd_data;

   dsel_mode_decode u_decode (
      .sel_n   (sel_n),
      .sel     (sel),
      .mute    (mute),
      .rd_wr   (rd_wr),
      .mode    (mode),
      .wr_go   (wr_go),
      .drive_on(drive_on),
      .echo_din(echo_din)
   );

   dsel_store #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_go  (wr_go),
      .addr   (addr),
      .din    (din),
      .rd_data(rd_data)
   );

   dsel_out_stage #(
      .DATA_W(DATA_W)
   ) u_out (
      .drive_on(drive_on),
      .echo_din(echo_din),
      .din     (din),
      .rd_data (rd_data),
      .dout    (dout),
      .dout_en (dout_en)
   );
endmodule

// File: rtl/dsel_sram_checker.sv
`timescale 1ns/1ps
module dsel_sram_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] din,
   input logic              sel_n,
   input logic              sel,
   input logic              mute,
   input logic              rd_wr,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);
   logic picked;
   assign picked = !sel_n && sel;

   assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !picked |-> !dout_en);

   assert_drive_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> (picked && !mute));

   assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(picked) && !$past(rd_wr) && picked && rd_wr && !mute
       && addr == $past(addr)) |-> dout == $past(din));

   assert_write_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && !rd_wr && !mute) |-> (dout_en && dout == din));

   assert_mute_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mute |-> !dout_en);

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> dout == '0);
endmodule

bind dsel_sram dsel_sram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
   .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .sel_n(sel_n), .sel(sel),
   .mute(mute), .rd_wr(rd_wr), .dout(dout), .dout_en(dout_en)
);

// File: tb/dsel_sram_bench.sv
`timescale 1ns/1ps
module dsel_sram_bench;
   localparam int AW = 8;
   localparam int DW = 4;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          sel_n = 1'b1;
   logic          sel = 1'b0;
   logic          mute = 1'b0;
   logic          rd_wr = 1'b1;
   logic [DW-1:0] dout;
   logic          dout_en;

   logic [DW-1:0] shadow [NW];
   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dsel_sram u_dsel_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .sel_n(sel_n), .sel(sel),
      .mute(mute), .rd_wr(rd_wr), .dout(dout), .dout_en(dout_en)
   );

   function automatic logic exp_en(logic s_n, logic s, logic m);
      return (!s_n && s && !m);
   endfunction

   function automatic logic [DW-1:0] exp_data(logic s_n, logic s, logic m, logic rw,
                                              logic [DW-1:0] stored, logic [DW-1:0] d);
      if (!exp_en(s_n, s, m)) return '0;
      return rw ? stored : d;
   endfunction

   function automatic string tag_of(logic s_n, logic s, logic m, logic rw);
      if (s_n || !s) return "R6";
      if (m) return "R5";
      return rw ? "R2" : "R4";
   endfunction

   task automatic check(string tag, logic [DW-1:0] exp_d, logic exp_e);
      n_cmp++;
      if (dout !== exp_d || dout_en !== exp_e) begin
         n_bad++;
         $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b (addr=%h)",
                  tag, dout, dout_en, exp_d, exp_e, addr);
      end
   endtask

   // Drive on the falling edge, check after settling, write lands at next rising edge.
   task automatic cycle(logic [AW-1:0] a, logic [DW-1:0] d, logic s_n, logic s,
                        logic m, logic rw, string tag);
      @(negedge clk);
      addr = a; din = d; sel_n = s_n; sel = s; mute = m; rd_wr = rw;
      #2;
      check(tag, exp_data(s_n, s, m, rw, shadow[a], d), exp_en(s_n, s, m));
      if (!s_n && s && !rw) shadow[a] = d;
   endtask

   task automatic read_word(logic [AW-1:0] a, string tag);
      cycle(a, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NW; i++) shadow[i] = '0;
      #5;
      // reset state: not driving
      check("R7", 4'h0, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R8: every word zero after reset
      for (int i = 0; i < NW; i++) read_word(AW'(i), "R8");

      // R1: each non-select combination of the two selects
      cycle(8'h10, 4'h5, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
      cycle(8'h10, 4'h5, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
      cycle(8'h10, 4'h5, 1'b1, 1'b0, 1'b0, 1'b1, "R1");

      // R3: write then read back, incl. lowest and highest address
      cycle(8'h00, 4'hA, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
      cycle(8'hFF, 4'h6, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
      read_word(8'h00, "R3");
      read_word(8'hFF, "R3");

      // R5: muted write still stores, muted read is silent
      cycle(8'h33, 4'hC, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
      cycle(8'h33, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
      cycle(8'h33, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
      read_word(8'h33, "R5");

      // R6: fill words, long deselect with write requests, read back
      for (int i = 0; i < 16; i++)
         cycle(AW'(8'h40 + i), DW'(i ^ 9), 1'b0, 1'b1, 1'b0, 1'b0, "R4");
      for (int k = 0; k < 60; k++) begin
         logic sn, s;
         sn = 1'($urandom);
         s  = sn ? 1'($urandom) : 1'b0;
         cycle(AW'(8'h40 + ($urandom % 16)), DW'($urandom), sn, s,
               1'($urandom), 1'b0, "R6");
      end
      for (int i = 0; i < 16; i++) read_word(AW'(8'h40 + i), "R6");

      // random traffic concentrated on sixteen words
      for (int k = 0; k < 4000; k++) begin
         logic [AW-1:0] a;
         logic sn, s, m, rw;
         a  = ($urandom % 4 == 0) ? AW'($urandom) : AW'(8'h80 + ($urandom % 16));
         sn = ($urandom % 4 == 0);
         s  = ($urandom % 4 != 0);
         m  = ($urandom % 4 == 0);
         rw = 1'($urandom);
         cycle(a, DW'($urandom), sn, s, m, rw, tag_of(sn, s, m, rw));
      end
      for (int i = 0; i < 16; i++) read_word(AW'(8'h80 + i), "R3");

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule